// File: doc/BRIEF.md
# Conditional Trap Compare Evaluator

This block decides whether a conditional trap instruction fires. Two operands are compared under five relations at once: unsigned greater, unsigned less, equal, signed greater and signed less. The instruction's 5-bit condition mask selects which of these relations may cause a trap. A separate vector of forced trap causes overrides the compare entirely: any nonzero bit in it makes the trap happen.

A mode input selects either a full 64-bit comparison or a comparison on the low words only. In narrow mode, the signed relations see each low word sign-extended and the unsigned relations see it zero-extended. Equality is judged on the unsigned pair. The block is purely combinational. Its result feeds the stage that builds interrupt state and redirects the program counter, and that stage is outside this block.

Top module: `trapcmp_eval`

## Requirements
- R1: In wide mode (`narrow_mode`=0), the signed relations compare the full 64-bit operands as two's complement values.
- R2: In narrow mode (`narrow_mode`=1), the signed relations compare the low 32 bits of each operand sign-extended to 64 bits. The upper 32 bits of the operands have no effect on them.
- R3: The unsigned relations compare the full operands in wide mode and the zero-extended low 32 bits in narrow mode.
- R4: Equality is judged on the unsigned operand pair. In narrow mode, only the low words decide it.
- R5: `cmp_flags` carries the relations in this order: bit 0 unsigned greater, bit 1 unsigned less, bit 2 equal, bit 3 signed greater, bit 4 signed less. Within each of the unsigned and signed groups, exactly one of greater, less or equal is set.
- R6: When `force_cause` is zero, `take_trap` is 1 exactly when (`cmp_flags` AND `cond_mask`) has a bit set.
- R7: `take_trap` is 1 whenever any bit of `force_cause` is set, whatever the operands and mask.
- R8: A mask of 0 with no forced cause never traps. A mask of 5'b11111 always traps.
- R9: Outputs depend only on the current inputs, with no clock, reset or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 64 | First compare operand |
| opb | input | 64 | Second compare operand |
| narrow_mode | input | 1 | 1 selects a low-word (32-bit) comparison |
| cond_mask | input | 5 | Condition select from the instruction, same bit order as cmp_flags |
| force_cause | input | 5 | Forced trap causes; any set bit forces the trap |
| take_trap | output | 1 | Trap decision |
| cmp_flags | output | 5 | Compare results {slt, sgt, eq, ult, ugt} |

## Verification
Assertions placed next to the logic check the following whenever the inputs change:
- the narrow-mode extensions produce correct upper bits;
- each of the signed and unsigned groups has exactly one of greater, less and equal set;
- a forced cause always traps;
- a zero mask with no forced cause never traps.

Only the bench's scenarios can show that the relations are computed correctly, because correct values need a reference. These include the 0x80000000 against 0x7FFFFFFF pair, where the signed and unsigned orders disagree in narrow mode but agree in wide mode. The bench scenarios also show that upper-word garbage is ignored in narrow mode and that the mask selects the right flag bits.

// File: rtl/trapcmp_pkg.sv
`timescale 1ns/1ps
package trapcmp_pkg;
  localparam int REL_COUNT = 5;
  localparam int IDX_UGT = 0;
  localparam int IDX_ULT = 1;
  localparam int IDX_EQ  = 2;
  localparam int IDX_SGT = 3;
  localparam int IDX_SLT = 4;

  // packed MSB first, so ugt lands on bit 0 and slt on bit 4
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } rel_flags_t;
endpackage

// File: rtl/trapcmp_operand_prep.sv
`timescale 1ns/1ps
module trapcmp_operand_prep #(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32
) (
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              narrow,
  output logic [DATA_W-1:0] sgn_a,
  output logic [DATA_W-1:0] sgn_b,
  output logic [DATA_W-1:0] uns_a,
  output logic [DATA_W-1:0] uns_b
);
  localparam int UP_W = DATA_W - HALF_W;

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] x,
                                               input logic nar,
                                               input logic sext);
    logic fill;
    fill = sext & x[HALF_W-1];
    if (nar) widen = {{UP_W{fill}}, x[HALF_W-1:0]};
    else     widen = x;
  endfunction

  always_comb begin
    sgn_a = widen(in_a, narrow, 1'b1);
    sgn_b = widen(in_b, narrow, 1'b1);
    uns_a = widen(in_a, narrow, 1'b0);
    uns_b = widen(in_b, narrow, 1'b0);
  end

  always_comb begin
    if (narrow) begin
      p_zext_upper_r3: assert (uns_a[DATA_W-1:HALF_W] == '0 && uns_b[DATA_W-1:HALF_W] == '0)
        else $error("R3 zero-extension upper bits not clear");
      p_sext_upper_r2: assert ((sgn_a[DATA_W-1:HALF_W] == {UP_W{in_a[HALF_W-1]}}) &&
                               (sgn_b[DATA_W-1:HALF_W] == {UP_W{in_b[HALF_W-1]}}))
        else $error("R2 sign-extension upper bits wrong");
    end
  end
endmodule

// File: rtl/trapcmp_relations.sv
`timescale 1ns/1ps
module trapcmp_relations
  import trapcmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] sgn_a,
  input  logic [DATA_W-1:0] sgn_b,
  input  logic [DATA_W-1:0] uns_a,
  input  logic [DATA_W-1:0] uns_b,
  output rel_flags_t        flags
);
  logic s_less, s_more, u_less, u_more, same;

  always_comb begin
    s_less = $signed(sgn_a) < $signed(sgn_b);
    s_more = $signed(sgn_a) > $signed(sgn_b);
    u_less = uns_a < uns_b;
    u_more = uns_a > uns_b;
    same   = uns_a == uns_b;
    flags  = '{slt: s_less, sgt: s_more, eq: same, ult: u_less, ugt: u_more};
  end

  always_comb begin
    p_unsigned_one_r5: assert ($onehot({flags.ugt, flags.ult, flags.eq}))
      else $error("R5 unsigned relation group not one-hot");
    p_signed_one_r5: assert ($onehot({flags.sgt, flags.slt, flags.eq}))
      else $error("R5 signed relation group not one-hot");
  end
endmodule

// File: rtl/trapcmp_decide.sv
`timescale 1ns/1ps
module trapcmp_decide
  import trapcmp_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  rel_flags_t           flags,
  input  logic [REL_COUNT-1:0] mask,
  input  logic [CAUSE_W-1:0]   cause,
  output logic                 take
);
  logic cond_hit, forced;

  always_comb begin
    cond_hit = |(flags & mask);
    forced   = |cause;
    take     = cond_hit | forced;
  end

  always_comb begin
    if (cause != '0) begin
      p_forced_takes_r7: assert (take) else $error("R7 forced cause did not trap");
    end
    if (cause == '0 && mask == '0) begin
      p_zero_mask_quiet_r8: assert (!take) else $error("R8 zero mask trapped");
    end
  end
endmodule

// File: rtl/trapcmp_eval.sv
`timescale 1ns/1ps
module trapcmp_eval
  import trapcmp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int HALF_W  = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  input  logic                 narrow_mode,
  input  logic [REL_COUNT-1:0] cond_mask,
  input  logic [CAUSE_W-1:0]   force_cause,
  output logic                 take_trap,
  output logic [REL_COUNT-1:0] cmp_flags
);
  logic [DATA_W-1:0] s_a, s_b, u_a, u_b;
  rel_flags_t        rel;

  trapcmp_operand_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
    .in_a(opa), .in_b(opb), .narrow(narrow_mode),
    .sgn_a(s_a), .sgn_b(s_b), .uns_a(u_a), .uns_b(u_b)
  );

  trapcmp_relations #(.DATA_W(DATA_W)) u_rel (
    .sgn_a(s_a), .sgn_b(s_b), .uns_a(u_a), .uns_b(u_b), .flags(rel)
  );

  trapcmp_decide #(.CAUSE_W(CAUSE_W)) u_dec (
    .flags(rel), .mask(cond_mask), .cause(force_cause), .take(take_trap)
  );

  assign cmp_flags = rel;

  always_comb begin
    if (cond_mask == '1) begin
      p_full_mask_traps_r8: assert (take_trap) else $error("R8 full mask did not trap");
    end
  end
endmodule

// File: tb/trapcmp_eval_test.sv
`timescale 1ns/1ps
module trapcmp_eval_test;
  logic        clk = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        narrow_mode = 1'b0;
  logic [4:0]  cond_mask = '0, force_cause = '0;
  logic        take_trap;
  logic [4:0]  cmp_flags;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trapcmp_eval uut (
    .opa(opa), .opb(opb), .narrow_mode(narrow_mode),
    .cond_mask(cond_mask), .force_cause(force_cause),
    .take_trap(take_trap), .cmp_flags(cmp_flags)
  );

  // Reference: signed order via sign-bit-flipped unsigned keys
  function automatic logic [4:0] ref_flags(input logic [63:0] a, input logic [63:0] b,
                                           input logic nar);
    logic [63:0] ua, ub, ka, kb;
    if (nar) begin
      ua = {32'h0, a[31:0]};
      ub = {32'h0, b[31:0]};
      ka = {32'h0, ~a[31], a[30:0]};
      kb = {32'h0, ~b[31], b[30:0]};
    end else begin
      ua = a; ub = b;
      ka = {~a[63], a[62:0]};
      kb = {~b[63], b[62:0]};
    end
    ref_flags = {ka < kb, ka > kb, ua == ub, ua < ub, ua > ub};
  endfunction

  function automatic logic ref_take(input logic [4:0] f, input logic [4:0] m,
                                    input logic [4:0] c);
    ref_take = (c != 0) || ((f & m) != 0);
  endfunction

  task automatic apply_and_check(input logic [63:0] a, input logic [63:0] b,
                                 input logic nar, input logic [4:0] m,
                                 input logic [4:0] c, input string tag);
    logic [4:0] ef;
    logic       et;
    @(posedge clk);
    opa = a; opb = b; narrow_mode = nar; cond_mask = m; force_cause = c;
    @(negedge clk);
    ef = ref_flags(a, b, nar);
    et = ref_take(ef, m, c);
    checks++;
    if (cmp_flags !== ef) begin
      errors++;
      $display("FAIL %s flags a=%h b=%h n=%0b got %b exp %b", tag, a, b, nar, cmp_flags, ef);
    end
    checks++;
    if (take_trap !== et) begin
      errors++;
      $display("FAIL %s take a=%h b=%h m=%b c=%b got %b exp %b", tag, a, b, m, c, take_trap, et);
    end
  endtask

  initial begin
    int seed;
    logic [63:0] ra, rb;
    seed = 1234;
    void'($urandom(seed));
    // R9: outputs settle from inputs alone, no reset needed
    apply_and_check(64'h0, 64'h0, 1'b0, 5'b00100, 5'h0, "R9 initial equal");
    // R1 R3: wide boundary pair, both orders agree
    apply_and_check(64'h8000_0000, 64'h7FFF_FFFF, 1'b0, 5'b01001, 5'h0, "R1 R3 wide boundary");
    // R2 R3: narrow boundary pair, signed and unsigned orders disagree
    apply_and_check(64'h8000_0000, 64'h7FFF_FFFF, 1'b1, 5'b10001, 5'h0, "R2 R3 narrow boundary");
    apply_and_check(64'h8000_0000, 64'h7FFF_FFFF, 1'b1, 5'b01000, 5'h0, "R2 narrow sgt masked");
    apply_and_check(64'h8000_0000_0000_0000, 64'h1, 1'b0, 5'b10000, 5'h0, "R1 wide negative");
    // R4: upper garbage ignored in narrow mode
    apply_and_check(64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_0005, 1'b1, 5'b00100, 5'h0, "R4 narrow eq");
    apply_and_check(64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_0005, 1'b0, 5'b00100, 5'h0, "R4 wide not eq");
    apply_and_check(64'hDEAD_BEEF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 5'b10010, 5'h0, "R2 R3 upper ignored");
    // R5: bit order, each single mask bit alone
    for (int k = 0; k < 5; k++)
      apply_and_check(64'h5, 64'h9, 1'b0, 5'(1 << k), 5'h0, "R5 R6 single mask bit");
    // R7: forced causes
    for (int k = 0; k < 5; k++)
      apply_and_check(64'h3, 64'h3, 1'b0, 5'h0, 5'(1 << k), "R7 forced cause");
    // R8: zero mask and full mask
    apply_and_check(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 5'h0, 5'h0, "R8 zero mask");
    apply_and_check(64'h7, 64'h7, 1'b1, 5'h1F, 5'h0, "R8 full mask");
    // random mix
    for (int i = 0; i < 600; i++) begin
      ra = {$urandom, $urandom};
      rb = ($urandom_range(0, 3) == 0) ? ra ^ {$urandom, 32'h0} : {$urandom, $urandom};
      apply_and_check(ra, rb, 1'($urandom_range(0, 1)), 5'($urandom),
                      ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0, "R1 R2 R3 R4 R6 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule